// File: doc/BRIEF.md
# Inband Loopback Code Detector

This block watches a recovered receive bit stream, one bit for each strobe of a bit enable. It keeps a network-loopback flag that a far end can raise and lower by sending a repeating code. The activation code is a five-bit cycle with a single mark (`00001`). The release code is a three-bit cycle with a single mark (`001`). A code counts only after it has been received without a break for a long window. By default that window is five seconds at 1.544 Mb/s, and a parameter sets it in bit periods. Because the two codes are different, they act as a hysteresis pair.

Detection runs only while the remote-loopback, local-loopback and transmit-all-ones controls are all high. Turning on either loopback control forces the flag low. An active-low interrupt request reports every change of the flag and of an incoming loss-of-signal status. It is built as open drain: the pin is driven only while a change is pending. The host clears each source with its own clear strobe.

Top module: `inband_loopback_det`

## Requirements
- R1: After reset, `lpbk_flag` is 0, `irq_n` is 1 and `irq_oe` is 0.
- R2: When detection is enabled, a bit accepted with `bit_en` high is conforming for a code of length L if both of these hold:
  - it equals the accepted bit L positions earlier;
  - the last L accepted bits, counting this one, hold exactly one 1.
  
  The flag sets at the clock edge of the RUN_LEN-th consecutive conforming bit of the activation code (L = 5). Before any bit is accepted, the bit history reads as all zeros.
- R3: Any non-conforming accepted bit restarts that code's run count from zero, so a full new run of RUN_LEN conforming bits is needed.
- R4: The flag clears at the clock edge of the RUN_LEN-th consecutive conforming bit of the release code (L = 3).
- R5: Detection is enabled only while `rloop_in`, `lloop_in` and `taos_in` are all 1. In any clock cycle where they are not all 1:
  - both run counts and both bit histories return to their reset state;
  - the flag keeps its value.
- R6: A 0-to-1 transition of `rloop_in` or of `lloop_in` clears the flag at that clock edge. This takes priority over a code event.
- R7: A change of the flag, in either direction, drives `irq_n` low and `irq_oe` high at the same edge.
- R8: A change of `los_in` from its value in the previous cycle drives `irq_n` low and `irq_oe` high at the next edge. The previous value reads 0 after reset.
- R9: Each interrupt source stays pending until its own clear strobe: `clr_los` for loss of signal, `clr_lpbk` for the flag. A new change in the same cycle as its clear keeps that source pending. `irq_n` is high only when neither source is pending.
- R10: Detection does not depend on the phase of the code: a stream that starts at any rotation of the activation code sets the flag.
- R11: Cycles with `bit_en` low are ignored: they neither advance nor restart a run count, whatever `rx_bit` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `rx_bit` for one clock |
| rx_bit | input | 1 | Recovered receive data bit |
| rloop_in | input | 1 | Remote loopback control |
| lloop_in | input | 1 | Local loopback control |
| taos_in | input | 1 | Transmit-all-ones control |
| los_in | input | 1 | Loss-of-signal status |
| clr_los | input | 1 | Host strobe clearing the loss-of-signal pending bit |
| clr_lpbk | input | 1 | Host strobe clearing the loopback-change pending bit |
| lpbk_flag | output | 1 | Network loopback status flag |
| irq_n | output | 1 | Active-low interrupt request level |
| irq_oe | output | 1 | Output enable of the open-drain interrupt pin |

## Verification
If a run counter held a wrong count, the flag would change early or late. That shows on `lpbk_flag` at the exact accepted bit where the run should complete, so the bench samples one bit before and one bit after that point. If a bit history were stale or misaligned, a broken code would fail to restart the run. A phase-shifted code would also set the flag on the wrong bit. Both show within one run length. If a pending bit were wrong, `irq_n` would not go low on the edge of a change, would go high before its own strobe, or would stay low after it, so each strobe is followed by a check one cycle later.

// File: rtl/ibl_pkg.sv
package ibl_pkg;

    // Code lengths of the two inband codes; the phase-free comparator
    // relies on each code holding exactly one mark per period.
    localparam int unsigned ACT_CODE_LEN = 5;
    localparam int unsigned REL_CODE_LEN = 3;
    localparam int unsigned DEF_RUN_LEN  = 1544000 * 5;

    typedef enum logic [1:0] {
        FLAG_HOLD  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLR   = 2'd2,
        FLAG_FORCE = 2'd3
    } flag_op_e;

    typedef struct packed {
        logic act_hit;
        logic rel_hit;
    } code_ev_t;

    typedef struct packed {
        logic los;
        logic lpbk;
    } irq_pend_t;

    function automatic flag_op_e pick_op(input logic force_clr, input code_ev_t ev);
        if (force_clr)       return FLAG_FORCE;
        else if (ev.rel_hit) return FLAG_CLR;
        else if (ev.act_hit) return FLAG_SET;
        else                 return FLAG_HOLD;
    endfunction

endpackage

// File: rtl/ibl_code_match.sv
module ibl_code_match #(
    parameter int unsigned CODE_LEN = 5,
    parameter int unsigned RUN_LEN  = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bit_en,
    input  logic rx_bit,
    output logic hit
);
    localparam int unsigned CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);
    localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

    logic [CODE_LEN-1:0] hist;
    logic [CODE_LEN-1:0] window;
    logic [CW-1:0]       run_cnt;
    logic                periodic;
    logic                one_mark;
    logic                good;

    assign window   = {hist[CODE_LEN-2:0], rx_bit};
    assign periodic = (rx_bit == hist[CODE_LEN-1]);
    assign one_mark = ($countones(window) == 1);
    assign good     = periodic && one_mark;
    assign hit      = bit_en && !clear && good && (run_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hist    <= '0;
            run_cnt <= '0;
        end else if (bit_en) begin
            hist <= window;
            if (!good)
                run_cnt <= '0;
            else if (run_cnt != FULL)
                run_cnt <= run_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ibl_flag_ctrl.sv
module ibl_flag_ctrl
    import ibl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rloop_in,
    input  logic     lloop_in,
    input  code_ev_t ev,
    output logic     flag,
    output logic     toggle
);
    logic     rl_q;
    logic     ll_q;
    logic     force_clr;
    logic     flag_nxt;
    flag_op_e op;

    assign force_clr = (rloop_in && !rl_q) || (lloop_in && !ll_q);
    assign op        = pick_op(force_clr, ev);

    always_comb begin
        unique case (op)
            FLAG_SET:   flag_nxt = 1'b1;
            FLAG_CLR:   flag_nxt = 1'b0;
            FLAG_FORCE: flag_nxt = 1'b0;
            default:    flag_nxt = flag;
        endcase
    end

    assign toggle = (flag_nxt != flag);

    always_ff @(posedge clk) begin
        rl_q <= rloop_in;
        ll_q <= lloop_in;
        if (rst)
            flag <= 1'b0;
        else
            flag <= flag_nxt;
    end

endmodule

// File: rtl/ibl_irq_ctrl.sv
module ibl_irq_ctrl
    import ibl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic los_in,
    input  logic flag_toggle,
    input  logic clr_los,
    input  logic clr_lpbk,
    output logic irq_n,
    output logic irq_oe
);
    irq_pend_t pend;
    logic      los_q;
    logic      los_chg;

    assign los_chg = los_in ^ los_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            los_q <= 1'b0;
            pend  <= '0;
        end else begin
            los_q <= los_in;
            if (los_chg)       pend.los <= 1'b1;
            else if (clr_los)  pend.los <= 1'b0;
            if (flag_toggle)   pend.lpbk <= 1'b1;
            else if (clr_lpbk) pend.lpbk <= 1'b0;
        end
    end

    assign irq_oe = |pend;
    assign irq_n  = ~(|pend);

endmodule

// File: rtl/inband_loopback_det.sv
module inband_loopback_det
    import ibl_pkg::*;
#(
    parameter int unsigned RUN_LEN = DEF_RUN_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic rloop_in,
    input  logic lloop_in,
    input  logic taos_in,
    input  logic los_in,
    input  logic clr_los,
    input  logic clr_lpbk,
    output logic lpbk_flag,
    output logic irq_n,
    output logic irq_oe
);
    localparam int unsigned NCODES = 2;
    localparam int unsigned CODE_LENS [NCODES] = '{ACT_CODE_LEN, REL_CODE_LEN};

    logic              det_en;
    logic [NCODES-1:0] hits;
    code_ev_t          ev;
    logic              flag_toggle;

    assign det_en = rloop_in && lloop_in && taos_in;

    for (genvar g = 0; g < NCODES; g++) begin : g_code
        ibl_code_match #(
            .CODE_LEN (CODE_LENS[g]),
            .RUN_LEN  (RUN_LEN)
        ) u_match (
            .clk    (clk),
            .rst    (rst),
            .clear  (!det_en),
            .bit_en (bit_en),
            .rx_bit (rx_bit),
            .hit    (hits[g])
        );
    end

    assign ev.act_hit = hits[0];
    assign ev.rel_hit = hits[1];

    ibl_flag_ctrl u_flag (
        .clk      (clk),
        .rst      (rst),
        .rloop_in (rloop_in),
        .lloop_in (lloop_in),
        .ev       (ev),
        .flag     (lpbk_flag),
        .toggle   (flag_toggle)
    );

    ibl_irq_ctrl u_irq (
        .clk         (clk),
        .rst         (rst),
        .los_in      (los_in),
        .flag_toggle (flag_toggle),
        .clr_los     (clr_los),
        .clr_lpbk    (clr_lpbk),
        .irq_n       (irq_n),
        .irq_oe      (irq_oe)
    );

endmodule

// File: rtl/ibl_checks.sv
module ibl_checks (
    input logic clk,
    input logic rst,
    input logic rloop_in,
    input logic lloop_in,
    input logic taos_in,
    input logic clr_los,
    input logic clr_lpbk,
    input logic lpbk_flag,
    input logic irq_n,
    input logic irq_oe
);
    // R5
    flag_rise_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lpbk_flag) |-> $past(rloop_in && lloop_in && taos_in));

    // R6
    rloop_force_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rloop_in) |=> !lpbk_flag);

    // R6
    lloop_force_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lloop_in) |=> !lpbk_flag);

    // R7
    flag_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (lpbk_flag != $past(lpbk_flag)) |-> (!irq_n && irq_oe));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !clr_los && !clr_lpbk) |=> !irq_n);

endmodule

bind inband_loopback_det ibl_checks u_chk (
    .clk       (clk),
    .rst       (rst),
    .rloop_in  (rloop_in),
    .lloop_in  (lloop_in),
    .taos_in   (taos_in),
    .clr_los   (clr_los),
    .clr_lpbk  (clr_lpbk),
    .lpbk_flag (lpbk_flag),
    .irq_n     (irq_n),
    .irq_oe    (irq_oe)
);

// File: tb/inband_loopback_det_bench.sv
module inband_loopback_det_bench;
    localparam int unsigned N = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0, rx_bit = 1'b0;
    logic rloop_in = 1'b0, lloop_in = 1'b0, taos_in = 1'b0, los_in = 1'b0;
    logic clr_los = 1'b0, clr_lpbk = 1'b0;
    logic lpbk_flag, irq_n, irq_oe;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    inband_loopback_det #(.RUN_LEN(N)) u_inband_loopback_det (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
        .rloop_in(rloop_in), .lloop_in(lloop_in), .taos_in(taos_in),
        .los_in(los_in), .clr_los(clr_los), .clr_lpbk(clr_lpbk),
        .lpbk_flag(lpbk_flag), .irq_n(irq_n), .irq_oe(irq_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic send_bit(input logic b);
        rx_bit = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic set_ctrl(input logic r, input logic l, input logic t);
        rloop_in = r; lloop_in = l; taos_in = t;
        @(negedge clk);
    endtask

    task automatic clr_lp();
        clr_lpbk = 1'b1;
        @(negedge clk);
        clr_lpbk = 1'b0;
    endtask

    function automatic logic act_bit(input int i);
        return ((i % 5) == 4);
    endfunction

    function automatic logic rel_bit(input int i);
        return ((i % 3) == 2);
    endfunction

    task automatic t_reset();
        check("R1 flag", lpbk_flag, 0);
        check("R1 irq_n", irq_n, 1);
        check("R1 irq_oe", irq_oe, 0);
    endtask

    task automatic t_set();
        set_ctrl(1, 1, 1);
        for (int i = 0; i < 24; i++) send_bit(act_bit(i));
        check("R2 flag before run end", lpbk_flag, 0);
        check("R7 irq before change", irq_n, 1);
        send_bit(act_bit(24));
        check("R2 flag at run end", lpbk_flag, 1);
        check("R7 irq_n on set", irq_n, 0);
        check("R7 irq_oe on set", irq_oe, 1);
        clr_lp();
        check("R9 irq after clr_lpbk", irq_n, 1);
    endtask

    task automatic t_clear();
        set_ctrl(1, 1, 0);
        set_ctrl(1, 1, 1);
        check("R5 flag held while disabled", lpbk_flag, 1);
        for (int i = 0; i < 22; i++) send_bit(rel_bit(i));
        check("R4 flag before run end", lpbk_flag, 1);
        send_bit(rel_bit(22));
        check("R4 flag at run end", lpbk_flag, 0);
        check("R7 irq_n on clear", irq_n, 0);
        clr_lp();
    endtask

    task automatic t_break();
        set_ctrl(1, 1, 0);
        set_ctrl(1, 1, 1);
        for (int i = 0; i < 47; i++) begin
            send_bit((i == 21) ? 1'b1 : act_bit(i));
            if (i == 24) check("R3 no set after break", lpbk_flag, 0);
            if (i == 45) check("R3 flag one bit before rerun", lpbk_flag, 0);
        end
        check("R3 flag after full rerun", lpbk_flag, 1);
        clr_lp();
    endtask

    task automatic t_force();
        set_ctrl(1, 0, 1);
        check("R6 fall keeps flag", lpbk_flag, 1);
        set_ctrl(1, 1, 1);
        check("R6 rise clears flag", lpbk_flag, 0);
        check("R7 irq on forced clear", irq_n, 0);
        clr_lp();
    endtask

    task automatic t_phase();
        for (int i = 0; i < 22; i++) send_bit(act_bit(i + 2));
        check("R10 shifted phase before run end", lpbk_flag, 0);
        send_bit(act_bit(24));
        check("R10 shifted phase sets", lpbk_flag, 1);
        clr_lp();
    endtask

    task automatic t_disabled();
        set_ctrl(1, 1, 0);
        for (int i = 0; i < 40; i++) send_bit(rel_bit(i));
        check("R5 release code ignored while disabled", lpbk_flag, 1);
        check("R5 no irq while disabled", irq_n, 1);
        set_ctrl(1, 1, 1);
        check("R5 flag held on re-enable", lpbk_flag, 1);
    endtask

    task automatic t_gate();
        set_ctrl(0, 1, 1);
        set_ctrl(1, 1, 1);
        check("R6 rloop rise clears flag", lpbk_flag, 0);
        clr_lp();
        for (int i = 0; i < 10; i++) send_bit(act_bit(i));
        rx_bit = 1'b1;
        for (int k = 0; k < 30; k++) begin
            rx_bit = k[0];
            @(negedge clk);
        end
        for (int i = 10; i < 24; i++) send_bit(act_bit(i));
        check("R11 gated cycles not counted", lpbk_flag, 0);
        send_bit(act_bit(24));
        check("R11 run completes across gap", lpbk_flag, 1);
        clr_lp();
    endtask

    task automatic t_los();
        los_in = 1'b1;
        @(negedge clk);
        check("R8 irq_n on los change", irq_n, 0);
        check("R8 irq_oe on los change", irq_oe, 1);
        clr_lp();
        check("R9 wrong clear keeps irq", irq_n, 0);
        clr_los = 1'b1;
        @(negedge clk);
        clr_los = 1'b0;
        check("R9 clr_los releases irq", irq_n, 1);
        los_in = 1'b0;
        clr_los = 1'b1;
        @(negedge clk);
        clr_los = 1'b0;
        check("R9 change beats clear", irq_n, 0);
        clr_los = 1'b1;
        @(negedge clk);
        clr_los = 1'b0;
        check("R9 later clear releases irq", irq_oe, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_set();
        t_clear();
        t_break();
        t_force();
        t_phase();
        t_disabled();
        t_gate();
        t_los();
        summary();
    end

endmodule